// File: doc/BRIEF.md
# Byte-Wide ADC Host Interface Controller

This block sits on the system side of a self-calibrating successive-approximation converter that hands over its 13-bit two's complement result through an 8-bit bus. After reset it performs one calibration pass. It then waits for either a calibrate request or a convert request. The convert request can ask for an auto-zero cycle ahead of sampling. The block produces every active-low strobe toward the converter: chip select, write, read, calibrate, auto-zero and sample/hold. It watches the converter's end-of-conversion and interrupt outputs.

After a conversion, the controller fetches the result in two byte accesses, high byte first. It joins the significant bits of both bytes into one signed word and announces that word with a single-cycle valid pulse. The width of each strobe is a parameter in clocks. Every wait on the converter is bounded by a second parameter. When a wait runs past that bound, a sticky error flag is raised, all strobes are released, and the controller returns to idle.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset is released, the calibrate strobe goes low for exactly PULSE_W clocks. Throughout that time, chip select and sample/hold stay high. Sample/hold is high at all times.
- R2: After the calibrate strobe, the controller waits for end-of-conversion to go low and then return high. A convert request that arrives before that point is dropped, and no write strobe follows from it.
- R3: In idle, a convert request drives chip select and write low together for exactly PULSE_W clocks, with calibrate held high. If a calibrate request arrives in the same cycle, the calibrate request wins and no write strobe is issued.
- R4: When the convert request carries auto-zero = 1, the auto-zero strobe is low from the first clock of the write strobe until the falling interrupt is seen. With auto-zero = 0, the auto-zero strobe stays high.
- R5: After the interrupt falls, the controller issues two read accesses. In each, chip select and read are low for exactly PULSE_W clocks. Between them, both lines are high for exactly PULSE_W clocks. The first access returns the high byte.
- R6: The result is {high byte bits 4..0, low byte bits 7..0}, read as 13-bit two's complement with bit 12 as the sign. High byte bits 7..5 carry only sign extension and have no effect on the result.
- R7: result_valid is high for exactly one clock, in the clock in which read returns high after the second access. The result keeps its value until the next valid pulse.
- R8: If any wait on the converter lasts TIMEOUT clocks, timeout_err goes high and every strobe is released (high), and the controller goes back to idle. During calibration, the count starts when calibrate returns high.
- R9: timeout_err stays high until the next request is accepted. It reads low from the first clock of the strobe that the request starts.
- R10: A calibrate request in idle repeats the full calibration sequence (R1, R2). Convert requests work again afterwards.
- R11: While reset is low, every converter strobe is high, result_valid and timeout_err are low, and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_req | input | 1 | Calibrate request, sampled in idle |
| conv_req | input | 1 | Convert request, sampled in idle |
| conv_az | input | 1 | Auto-zero option for the convert request |
| result | output | RES_W | Signed conversion result |
| result_valid | output | 1 | One-cycle pulse when result is updated |
| timeout_err | output | 1 | Sticky flag: a converter wait expired |
| adc_cs_n | output | 1 | Chip select strobe, active low |
| adc_wr_n | output | 1 | Write (start) strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_cal_n | output | 1 | Calibrate strobe, active low |
| adc_az_n | output | 1 | Auto-zero strobe, active low |
| adc_sh_n | output | 1 | Sample/hold control, held high |
| adc_eoc | input | 1 | End-of-conversion from converter, low while busy |
| adc_int_n | input | 1 | Interrupt from converter, low when result ready |
| adc_db | input | BYTE_W | Converter data bus |

## Verification
The hardest behaviour to reach is a convert request that lands while calibration is still running. From the ports, this looks identical to a request accepted in idle, except that no write strobe must ever follow. The bench acts as the converter. It holds end-of-conversion low for a long calibration window, pulses a convert request in the middle of that window, and then watches the write line for the rest of the busy period and for some time after. The bench also withholds end-of-conversion or the interrupt entirely, so that both timeout paths fire. It then checks that the next request clears the flag.

// File: rtl/adc_host_pkg.sv
// Shared types for the ADC host interface controller.
// Assumes: all converter strobes are active low.
package adc_host_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_CAL_LOW,
        ST_CAL_ACK,
        ST_CAL_BUSY,
        ST_IDLE,
        ST_WR_LOW,
        ST_CONV_WAIT,
        ST_RD_HI,
        ST_RD_GAP,
        ST_RD_LO
    } ctrl_state_e;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic cal_n;
        logic az_n;
    } strobe_t;

endpackage

// File: rtl/state_timer.sv
// Counts the clocks spent in the current controller state.
// Assumes: restart is high in the cycle before a state change, so the
// count reads 0 in the first cycle of every state. It saturates at MAX_CNT.
module state_timer #(
    parameter int CNT_W   = 8,
    parameter int MAX_CNT = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    // Clear on restart, otherwise count up to the saturation limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != CNT_W'(MAX_CNT))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/strobe_decode.sv
// Maps the controller state onto the active-low converter strobes.
// Assumes: state is a register, so each strobe changes only on a clock
// edge. Auto-zero follows az_hold only while a conversion is under way.
module strobe_decode
    import adc_host_pkg::*;
(
    input  ctrl_state_e state,
    input  logic        az_hold,
    output strobe_t     strb
);

    // Default everything inactive, then pull low per state.
    always_comb begin
        strb = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, cal_n: 1'b1, az_n: 1'b1};
        case (state)
            ST_CAL_LOW: strb.cal_n = 1'b0;
            ST_WR_LOW: begin
                strb.cs_n = 1'b0;
                strb.wr_n = 1'b0;
                strb.az_n = ~az_hold;
            end
            ST_CONV_WAIT: strb.az_n = ~az_hold;
            ST_RD_HI, ST_RD_LO: begin
                strb.cs_n = 1'b0;
                strb.rd_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/result_packer.sv
// Captures the two bus bytes and joins them into the signed result.
// Assumes: cap_hi comes before cap_lo. Only the low RES_W-BYTE_W bits
// of the high byte are significant; the rest are sign copies.
module result_packer #(
    parameter int BYTE_W = 8,
    parameter int RES_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [BYTE_W-1:0] bus,
    output logic [RES_W-1:0]  result,
    output logic              valid
);

    localparam int HI_BITS = RES_W - BYTE_W;

    logic [HI_BITS-1:0] hi_q;

    // Hold the significant part of the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (cap_hi)
            hi_q <= bus[HI_BITS-1:0];
    end

    // Join both bytes and raise valid for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= cap_lo;
            if (cap_lo)
                result <= {hi_q, bus};
        end
    end

endmodule

// File: rtl/adc_host_ctrl.sv
// Host-side controller for a byte-wide self-calibrating ADC.
// It calibrates after reset, then serves calibrate and convert requests.
// It fetches the result high byte first and flags waits that time out.
// Assumes: converter inputs are synchronous to clk; PULSE_W >= 2.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int PULSE_W = 3,
    parameter int TIMEOUT = 4096,
    parameter int BYTE_W  = 8,
    parameter int RES_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              conv_req,
    input  logic              conv_az,
    output logic [RES_W-1:0]  result,
    output logic              result_valid,
    output logic              timeout_err,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic              adc_cal_n,
    output logic              adc_az_n,
    output logic              adc_sh_n,
    input  logic              adc_eoc,
    input  logic              adc_int_n,
    input  logic [BYTE_W-1:0] adc_db
);

    localparam int LIMIT = (TIMEOUT > PULSE_W) ? TIMEOUT : PULSE_W;
    localparam int CNT_W = $clog2(LIMIT + 1);

    ctrl_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             pulse_end, wait_end;
    logic             accept, tmo, cap_hi, cap_lo;
    logic             az_q, err_q;
    strobe_t          strb;

    assign pulse_end = (cnt == CNT_W'(PULSE_W - 1));
    assign wait_end  = (cnt == CNT_W'(TIMEOUT - 1));

    state_timer #(
        .CNT_W   (CNT_W),
        .MAX_CNT (LIMIT)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nx != state),
        .count   (cnt)
    );

    // Next-state selection and the one-cycle control events.
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        tmo      = 1'b0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        case (state)
            ST_BOOT:    state_nx = ST_CAL_LOW;
            ST_CAL_LOW: if (pulse_end) state_nx = ST_CAL_ACK;
            ST_CAL_ACK: begin
                if (!adc_eoc)
                    state_nx = ST_CAL_BUSY;
                else if (wait_end) begin
                    tmo      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_CAL_BUSY: begin
                if (adc_eoc)
                    state_nx = ST_IDLE;
                else if (wait_end) begin
                    tmo      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (cal_req) begin
                    accept   = 1'b1;
                    state_nx = ST_CAL_LOW;
                end else if (conv_req) begin
                    accept   = 1'b1;
                    state_nx = ST_WR_LOW;
                end
            end
            ST_WR_LOW: if (pulse_end) state_nx = ST_CONV_WAIT;
            ST_CONV_WAIT: begin
                if (!adc_int_n)
                    state_nx = ST_RD_HI;
                else if (wait_end) begin
                    tmo      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_RD_HI: begin
                if (pulse_end) begin
                    cap_hi   = 1'b1;
                    state_nx = ST_RD_GAP;
                end
            end
            ST_RD_GAP: if (pulse_end) state_nx = ST_RD_LO;
            ST_RD_LO: begin
                if (pulse_end) begin
                    cap_lo   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_BOOT;
        else
            state <= state_nx;
    end

    // Latch the auto-zero option when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            az_q <= 1'b0;
        else if (state == ST_IDLE && state_nx == ST_WR_LOW)
            az_q <= conv_az;
    end

    // Sticky timeout flag, cleared when a new request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (tmo)
            err_q <= 1'b1;
        else if (accept)
            err_q <= 1'b0;
    end

    strobe_decode i_decode (
        .state   (state),
        .az_hold (az_q),
        .strb    (strb)
    );

    result_packer #(
        .BYTE_W (BYTE_W),
        .RES_W  (RES_W)
    ) i_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .bus    (adc_db),
        .result (result),
        .valid  (result_valid)
    );

    assign adc_cs_n    = strb.cs_n;
    assign adc_wr_n    = strb.wr_n;
    assign adc_rd_n    = strb.rd_n;
    assign adc_cal_n   = strb.cal_n;
    assign adc_az_n    = strb.az_n;
    assign adc_sh_n    = 1'b1;
    assign timeout_err = err_q;

endmodule

// File: rtl/adc_host_ctrl_chk.sv
// Protocol checker for adc_host_ctrl, attached with bind below.
// Assumes: synchronous active-low reset; it only observes ports.
module adc_host_ctrl_chk #(
    parameter int RES_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_cs_n,
    input logic             adc_wr_n,
    input logic             adc_rd_n,
    input logic             adc_cal_n,
    input logic             adc_az_n,
    input logic             adc_sh_n,
    input logic             result_valid,
    input logic [RES_W-1:0] result,
    input logic             timeout_err
);

    // R1
    cal_strobe_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cal_n |-> (adc_cs_n && adc_sh_n && adc_wr_n && adc_rd_n));

    // R3
    wr_strobe_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> (!adc_cs_n && adc_cal_n && adc_rd_n));

    // R5
    rd_strobe_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> (!adc_cs_n && adc_wr_n && adc_cal_n));

    // R4
    az_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_az_n |-> (adc_cal_n && adc_rd_n));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    // R8
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (adc_cs_n && adc_wr_n && adc_rd_n && adc_cal_n && adc_az_n));

    // R1
    sh_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sh_n);

endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.RES_W(RES_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_cs_n     (adc_cs_n),
    .adc_wr_n     (adc_wr_n),
    .adc_rd_n     (adc_rd_n),
    .adc_cal_n    (adc_cal_n),
    .adc_az_n     (adc_az_n),
    .adc_sh_n     (adc_sh_n),
    .result_valid (result_valid),
    .result       (result),
    .timeout_err  (timeout_err)
);

// File: tb/test_adc_host_ctrl.sv
// Directed bench: the bench models the converter inside each task.
module test_adc_host_ctrl;

    localparam int PW  = 4;
    localparam int TMO = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_req = 1'b0;
    logic        conv_req = 1'b0;
    logic        conv_az = 1'b0;
    logic [12:0] result;
    logic        result_valid, timeout_err;
    logic        adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n, adc_az_n, adc_sh_n;
    logic        adc_eoc = 1'b1;
    logic        adc_int_n = 1'b1;
    logic [7:0]  adc_db = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    adc_host_ctrl #(
        .PULSE_W (PW),
        .TIMEOUT (TMO)
    ) i_adc_host_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_req      (cal_req),
        .conv_req     (conv_req),
        .conv_az      (conv_az),
        .result       (result),
        .result_valid (result_valid),
        .timeout_err  (timeout_err),
        .adc_cs_n     (adc_cs_n),
        .adc_wr_n     (adc_wr_n),
        .adc_rd_n     (adc_rd_n),
        .adc_cal_n    (adc_cal_n),
        .adc_az_n     (adc_az_n),
        .adc_sh_n     (adc_sh_n),
        .adc_eoc      (adc_eoc),
        .adc_int_n    (adc_int_n),
        .adc_db       (adc_db)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R11: reset levels
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk({adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n, adc_az_n, adc_sh_n} == 6'h3F,
            "R11", "strobes in reset",
            int'({adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n, adc_az_n, adc_sh_n}), 63);
        chk(!result_valid && !timeout_err && result == 13'd0, "R11", "valid/err/result",
            int'({result_valid, timeout_err, result}), 0);
        rst_n = 1'b1;
    endtask

    // Converter model for calibration; respond=0 never drops eoc.
    // R1 R2 R8 R10
    task automatic cal_model(input bit respond, input bit poke_conv);
        int w = 0;
        int guard = 0;
        bit lvl_bad = 1'b0;
        bit wr_seen = 1'b0;
        while (adc_cal_n && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        while (!adc_cal_n) begin
            if (!adc_cs_n || !adc_sh_n) lvl_bad = 1'b1;
            w++;
            if (w == 2 && respond) adc_eoc = 1'b0;
            @(negedge clk);
        end
        chk(w == PW, "R1", "cal strobe width", w, PW);
        chk(!lvl_bad, "R1", "cs_n/sh_n high during cal", int'(lvl_bad), 0);
        if (respond) begin
            for (int i = 0; i < 60; i++) begin
                conv_req = (poke_conv && i == 10);
                if (!adc_wr_n) wr_seen = 1'b1;
                @(negedge clk);
            end
            adc_eoc = 1'b1;
            for (int i = 0; i < 20; i++) begin
                if (!adc_wr_n) wr_seen = 1'b1;
                @(negedge clk);
            end
            chk(!wr_seen, "R2", "no write strobe from request during cal", int'(wr_seen), 0);
            chk(!timeout_err, "R2", "no timeout on normal cal", int'(timeout_err), 0);
        end else begin
            int n = 0;
            while (!timeout_err && n < TMO + 20) begin
                if (!adc_wr_n) wr_seen = 1'b1;
                @(negedge clk);
                n++;
            end
            chk(n == TMO, "R8", "cal ack timeout clocks", n, TMO);
            chk(adc_cal_n && adc_cs_n, "R8", "strobes released on timeout",
                int'({adc_cal_n, adc_cs_n}), 3);
            chk(!wr_seen, "R3", "cal wins over convert", int'(wr_seen), 0);
        end
    endtask

    // One conversion with the bench playing the converter.
    // R3 R4 R5 R6 R7 R8 R9
    task automatic t_convert(input bit az, input logic [12:0] val,
                             input logic [2:0] hi_top, input bit respond);
        int w = 0;
        int g = 0;
        int guard = 0;
        bit az_bad = 1'b0;
        bit cs_bad = 1'b0;
        @(negedge clk);
        conv_req = 1'b1;
        conv_az  = az;
        @(negedge clk);
        conv_req = 1'b0;
        chk(!timeout_err, "R9", "error cleared on accept", int'(timeout_err), 0);
        while (!adc_wr_n) begin
            if (adc_cs_n || !adc_cal_n) cs_bad = 1'b1;
            if (adc_az_n != !az) az_bad = 1'b1;
            w++;
            @(negedge clk);
        end
        chk(w == PW, "R3", "write strobe width", w, PW);
        chk(!cs_bad, "R3", "cs_n low, cal_n high with write", int'(cs_bad), 0);
        adc_eoc = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (adc_az_n != !az) az_bad = 1'b1;
            @(negedge clk);
        end
        chk(!az_bad, "R4", "auto-zero level through conversion", int'(az_bad), int'(az));
        if (!respond) begin
            int n = 0;
            adc_eoc = 1'b1;
            while (!timeout_err && n < TMO + 20) begin
                @(negedge clk);
                n++;
            end
            chk(timeout_err, "R8", "timeout on missing interrupt", int'(timeout_err), 1);
            chk(adc_az_n && adc_cs_n && adc_rd_n, "R8", "strobes released",
                int'({adc_az_n, adc_cs_n, adc_rd_n}), 7);
            return;
        end
        adc_int_n = 1'b0;
        adc_eoc   = 1'b1;
        while (adc_rd_n && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        chk(!adc_cs_n && !adc_rd_n, "R5", "first read strobe", int'({adc_cs_n, adc_rd_n}), 0);
        chk(adc_az_n, "R4", "auto-zero released at interrupt", int'(adc_az_n), 1);
        adc_db = {hi_top, val[12:8]};
        w = 0;
        while (!adc_rd_n) begin
            w++;
            @(negedge clk);
        end
        chk(w == PW, "R5", "high read width", w, PW);
        adc_int_n = 1'b1;
        adc_db    = 8'hA5;
        while (adc_rd_n && g < 3 * PW) begin
            if (!adc_cs_n) cs_bad = 1'b1;
            g++;
            @(negedge clk);
        end
        chk(g == PW, "R5", "gap between reads", g, PW);
        chk(!cs_bad, "R5", "cs_n high in gap", int'(cs_bad), 0);
        adc_db = val[7:0];
        w = 0;
        while (!adc_rd_n) begin
            w++;
            @(negedge clk);
        end
        chk(w == PW, "R5", "low read width", w, PW);
        chk(result_valid, "R7", "valid as read ends", int'(result_valid), 1);
        chk(result == val, "R6", "assembled result", int'(result), int'(val));
        @(negedge clk);
        chk(!result_valid, "R7", "valid one clock", int'(result_valid), 0);
        chk(result == val, "R7", "result held", int'(result), int'(val));
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        cal_model(1'b1, 1'b1);
        t_convert(1'b0, 13'h0ABC, 3'b000, 1'b1);
        t_convert(1'b1, 13'h1FFF, 3'b111, 1'b1);
        t_convert(1'b0, 13'h1000, 3'b010, 1'b1);
        t_convert(1'b1, 13'h0000, 3'b000, 1'b0);
        t_convert(1'b0, 13'h0FFF, 3'b000, 1'b1);
        // R10 with a simultaneous convert request, no converter reply
        @(negedge clk);
        cal_req  = 1'b1;
        conv_req = 1'b1;
        @(negedge clk);
        cal_req  = 1'b0;
        conv_req = 1'b0;
        cal_model(1'b0, 1'b0);
        // R10 normal recalibration, then a conversion
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        chk(!timeout_err, "R9", "error cleared by cal request", int'(timeout_err), 0);
        cal_model(1'b1, 1'b0);
        t_convert(1'b1, 13'h0001, 3'b000, 1'b1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule